// File: doc/BRIEF.md
# Signature Chain Permission Evaluator

This block decides whether one section of a configuration image may be accepted. The image carries up to four signature chains. Each chain is anchored by a root entry, followed by zero to three public key entries and finally by the entry that signs the section header. Hash and signature arithmetic happen elsewhere. This block receives their results as flags: whether the root entry hash matched the fused value, whether each key entry signature and the header signature verified, and each key entry's permission nibble and cancellation field. It also receives the owner cancellation fuse vector and the section type being authorized.

On a start pulse the block walks the chains in index order, spending one cycle per entry. A chain is dropped at the first fault it meets: an absent chain, a root mismatch, a bad signature, a cancelled key, or a missing permission. The first chain that survives to its header check ends the walk with a pass and records that chain's index. If every chain is dropped, the result is a fail. The result is held until the next accepted start. All inputs other than `start` must stay stable from the start pulse until `done`.

Top module: `sig_chain_eval`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `win_idx` are all 0.
- R2: `start` is accepted only when neither `busy` nor `done` is high. `busy` rises in the following cycle. A `start` pulse while busy changes neither the result nor the latency.
- R3: Chains are examined in order 0, 1, 2, 3. A chain whose `chain_present` bit or `root_match` bit is 0 is skipped after one cycle.
- R4: Each public key entry takes one cycle. A chain costs 1 cycle for its root, plus 1 cycle for each key entry examined, plus 1 cycle if its header entry is reached. A chain is abandoned at the first key entry whose `key_sig_ok` bit is 0 or that is cancelled. Latency is counted from the clock edge that samples `start` to the edge after which `done` is high.
- R5: Each cancellation field is 6 bits. Bit 5 set marks an uncancellable key. Bits 4:0 hold the ID. A key is cancelled when bit 5 is 0 and `cancel_fuse[ID]` is 1, so every key carrying that ID is cancelled at once. The root entry is never cancelled.
- R6: A chain's effective permission is the bitwise AND of the permission nibbles of the key entries it actually holds (`key_count`). A chain with no key entries has all four permissions.
- R7: `sect_sel` picks the permission bit that is tested: 0 firmware, 1 logic-fabric I/O, core and partial reconfiguration, 2 processor-side I/O and first-stage boot loader, 3 debug certificate. A chain passes at its header only if `hdr_sig_ok` is 1 and the selected bit is set. A nibble with several bits set grants several section types.
- R8: The first chain that passes ends the walk. The outputs then show `pass`=1 and `win_idx` equal to that chain's index, and later chains are not examined.
- R9: If no chain passes, including the case where no chain is present, the outputs show `pass`=0 and `win_idx`=0.
- R10: `done` is a one-cycle pulse in the cycle after the decision. `pass` and `win_idx` are valid from that cycle and stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation |
| sect_sel | input | 2 | Section type index (permission bit number) |
| chain_present | input | 4 | Chain n exists in the image |
| root_match | input | 4 | Root entry hash of chain n equals the fused hash |
| key_count | input | 4x2 | Number of public key entries per chain (0 to 3) |
| key_sig_ok | input | 4x3 | Signature of key entry k in chain n verified |
| hdr_sig_ok | input | 4 | Header entry signature of chain n verified |
| key_perm | input | 4x3x4 | Permission nibble per key entry |
| key_cid | input | 4x3x6 | Cancellation field per key entry: uncancellable flag and ID |
| cancel_fuse | input | 32 | Owner cancellation fuses, one per ID |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Section accepted |
| win_idx | output | 2 | Index of the first passing chain |

## Verification
The key-entry cycle folds two checks into one decision: the signature flag and the fuse lookup. The bench forces them to disagree within one entry: a good signature with a blown fuse, and an uncancellable field under a blown fuse. The test is judged by the pass result and by the latency, which shows the exact entry where the chain was dropped. A second coincidence occurs when a header check fails on the last chain, so the advance and the end of the walk happen in the same cycle. Vectors with a failing final chain are judged on `pass`=0 and on a latency equal to the sum of the per-chain costs.

// File: rtl/sce_pkg.sv
package sce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROOT = 3'd1,
    ST_KEY  = 3'd2,
    ST_HDR  = 3'd3,
    ST_DONE = 3'd4
  } sce_state_e;
endpackage

// File: rtl/sce_key_check.sv
// Per-key liveness: signature verified and not revoked by a fuse.
module sce_key_check #(
  parameter int NUM_CHAINS = 4,
  parameter int MAX_KEYS   = 3,
  parameter int NUM_FUSES  = 32,
  parameter int CID_W      = 5
) (
  input  logic [NUM_CHAINS-1:0][MAX_KEYS-1:0]          key_sig_ok,
  input  logic [NUM_CHAINS-1:0][MAX_KEYS-1:0][CID_W:0] key_cid,
  input  logic [NUM_FUSES-1:0]                         cancel_fuse,
  output logic [NUM_CHAINS-1:0][MAX_KEYS-1:0]          key_alive
);
  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    for (genvar k = 0; k < MAX_KEYS; k++) begin : g_key
      logic [CID_W-1:0] id;
      logic             fixed;
      logic             revoked;
      assign id      = key_cid[c][k][CID_W-1:0];
      assign fixed   = key_cid[c][k][CID_W];
      assign revoked = ~fixed & cancel_fuse[id];
      assign key_alive[c][k] = key_sig_ok[c][k] & ~revoked;
    end
  end
endmodule

// File: rtl/sce_fsm.sv
// Walks chains and entries, one entry per cycle.
module sce_fsm
  import sce_pkg::*;
#(
  parameter int NUM_CHAINS = 4,
  parameter int KC_W       = 2,
  parameter int CI_W       = 2,
  parameter int KI_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             root_ok,
  input  logic             key_ok,
  input  logic [KC_W-1:0]  kcnt,
  input  logic             hdr_ok,
  output sce_state_e       state,
  output logic [CI_W-1:0]  chain_idx,
  output logic [KI_W-1:0]  key_idx,
  output logic             accept,
  output logic             win
);
  sce_state_e      state_nx;
  logic [CI_W-1:0] chain_nx;
  logic [KI_W-1:0] key_nx;
  logic            last_chain;
  logic            last_key;

  assign last_chain = (chain_idx == CI_W'(NUM_CHAINS - 1));
  assign last_key   = ((KC_W'(key_idx) + KC_W'(1)) == kcnt);
  assign accept     = (state == ST_IDLE) & start;
  assign win        = (state == ST_HDR) & hdr_ok;

  always_comb begin
    state_nx = state;
    chain_nx = chain_idx;
    key_nx   = key_idx;
    unique case (state)
      ST_IDLE: if (start) begin
        state_nx = ST_ROOT;
        chain_nx = '0;
      end
      ST_ROOT: begin
        key_nx = '0;
        if (!root_ok) begin
          if (last_chain) state_nx = ST_DONE;
          else chain_nx = chain_idx + CI_W'(1);
        end else if (kcnt == '0) begin
          state_nx = ST_HDR;
        end else begin
          state_nx = ST_KEY;
        end
      end
      ST_KEY: begin
        if (!key_ok) begin
          if (last_chain) state_nx = ST_DONE;
          else begin
            state_nx = ST_ROOT;
            chain_nx = chain_idx + CI_W'(1);
          end
        end else if (last_key) begin
          state_nx = ST_HDR;
        end else begin
          key_nx = key_idx + KI_W'(1);
        end
      end
      ST_HDR: begin
        if (hdr_ok || last_chain) state_nx = ST_DONE;
        else begin
          state_nx = ST_ROOT;
          chain_nx = chain_idx + CI_W'(1);
        end
      end
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      chain_idx <= '0;
      key_idx   <= '0;
    end else begin
      state     <= state_nx;
      chain_idx <= chain_nx;
      key_idx   <= key_nx;
    end
  end
endmodule

// File: rtl/sig_chain_eval.sv
// Signature chain permission evaluator (top).
module sig_chain_eval
  import sce_pkg::*;
#(
  parameter int NUM_CHAINS = 4,
  parameter int MAX_KEYS   = 3,
  parameter int PERM_W     = 4,
  parameter int NUM_FUSES  = 32,
  localparam int CID_W = $clog2(NUM_FUSES),
  localparam int SEL_W = (PERM_W > 1) ? $clog2(PERM_W) : 1,
  localparam int KC_W  = $clog2(MAX_KEYS + 1),
  localparam int KI_W  = (MAX_KEYS > 1) ? $clog2(MAX_KEYS) : 1,
  localparam int CI_W  = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             start,
  input  logic [SEL_W-1:0]                                 sect_sel,
  input  logic [NUM_CHAINS-1:0]                            chain_present,
  input  logic [NUM_CHAINS-1:0]                            root_match,
  input  logic [NUM_CHAINS-1:0][KC_W-1:0]                  key_count,
  input  logic [NUM_CHAINS-1:0][MAX_KEYS-1:0]              key_sig_ok,
  input  logic [NUM_CHAINS-1:0]                            hdr_sig_ok,
  input  logic [NUM_CHAINS-1:0][MAX_KEYS-1:0][PERM_W-1:0]  key_perm,
  input  logic [NUM_CHAINS-1:0][MAX_KEYS-1:0][CID_W:0]     key_cid,
  input  logic [NUM_FUSES-1:0]                             cancel_fuse,
  output logic                                             busy,
  output logic                                             done,
  output logic                                             pass,
  output logic [CI_W-1:0]                                  win_idx
);
  sce_state_e                          state;
  logic [CI_W-1:0]                     chain_idx;
  logic [KI_W-1:0]                     key_idx;
  logic                                accept;
  logic                                win;
  logic [NUM_CHAINS-1:0][MAX_KEYS-1:0] key_alive;
  logic                                root_ok;
  logic                                key_ok;
  logic                                hdr_ok;
  logic [KC_W-1:0]                     kcnt;
  logic [PERM_W-1:0]                   perm_cur;
  logic [PERM_W-1:0]                   acc_q;
  logic [PERM_W-1:0]                   acc_d;
  logic                                acc_en;
  logic [SEL_W-1:0]                    sect_q;
  logic                                pass_q;
  logic [CI_W-1:0]                     win_q;
  logic                                res_en;

  sce_key_check #(
    .NUM_CHAINS(NUM_CHAINS), .MAX_KEYS(MAX_KEYS),
    .NUM_FUSES(NUM_FUSES), .CID_W(CID_W)
  ) u_keys (
    .key_sig_ok (key_sig_ok),
    .key_cid    (key_cid),
    .cancel_fuse(cancel_fuse),
    .key_alive  (key_alive)
  );

  assign root_ok  = chain_present[chain_idx] & root_match[chain_idx];
  assign kcnt     = key_count[chain_idx];
  assign key_ok   = key_alive[chain_idx][key_idx];
  assign perm_cur = key_perm[chain_idx][key_idx];
  assign hdr_ok   = hdr_sig_ok[chain_idx] & acc_q[sect_q];

  sce_fsm #(
    .NUM_CHAINS(NUM_CHAINS), .KC_W(KC_W), .CI_W(CI_W), .KI_W(KI_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .root_ok  (root_ok),
    .key_ok   (key_ok),
    .kcnt     (kcnt),
    .hdr_ok   (hdr_ok),
    .state    (state),
    .chain_idx(chain_idx),
    .key_idx  (key_idx),
    .accept   (accept),
    .win      (win)
  );

  // Permission accumulator: set at root, narrowed by each live key.
  assign acc_en = (state == ST_ROOT) | ((state == ST_KEY) & key_ok);
  assign acc_d  = (state == ST_ROOT) ? {PERM_W{1'b1}} : (acc_q & perm_cur);
  assign res_en = accept | win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      sect_q <= '0;
      pass_q <= 1'b0;
      win_q  <= '0;
    end else begin
      if (acc_en) acc_q  <= acc_d;
      if (accept) sect_q <= sect_sel;
      if (res_en) begin
        pass_q <= win;
        win_q  <= win ? chain_idx : '0;
      end
    end
  end

  assign busy    = (state == ST_ROOT) | (state == ST_KEY) | (state == ST_HDR);
  assign done    = (state == ST_DONE);
  assign pass    = pass_q;
  assign win_idx = win_q;
endmodule

// File: rtl/sce_chk.sv
// Property checker attached to the evaluator.
module sce_chk #(
  parameter int NUM_CHAINS = 4,
  parameter int CI_W       = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [NUM_CHAINS-1:0] chain_present,
  input logic [NUM_CHAINS-1:0] root_match,
  input logic [NUM_CHAINS-1:0] hdr_sig_ok,
  input logic                  busy,
  input logic                  done,
  input logic                  pass,
  input logic [CI_W-1:0]       win_idx
);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pass) && $stable(win_idx)));

  assert_winner_root_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (chain_present[win_idx] && root_match[win_idx]));

  assert_winner_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> hdr_sig_ok[win_idx]);

  assert_empty_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (chain_present == '0)) |-> (!pass && (win_idx == '0)));
endmodule

bind sig_chain_eval sce_chk #(
  .NUM_CHAINS(NUM_CHAINS), .CI_W(CI_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .chain_present(chain_present),
  .root_match   (root_match),
  .hdr_sig_ok   (hdr_sig_ok),
  .busy         (busy),
  .done         (done),
  .pass         (pass),
  .win_idx      (win_idx)
);

// File: tb/sig_chain_eval_tb.sv
`timescale 1ns/1ps
module sig_chain_eval_tb;
  logic                  clk;
  logic                  rst_n;
  logic                  start;
  logic [1:0]            sect_sel;
  logic [3:0]            chain_present;
  logic [3:0]            root_match;
  logic [3:0][1:0]       key_count;
  logic [3:0][2:0]       key_sig_ok;
  logic [3:0]            hdr_sig_ok;
  logic [3:0][2:0][3:0]  key_perm;
  logic [3:0][2:0][5:0]  key_cid;
  logic [31:0]           cancel_fuse;
  logic                  busy;
  logic                  done;
  logic                  pass;
  logic [1:0]            win_idx;

  int checks = 0;
  int fails  = 0;

  sig_chain_eval u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sect_sel(sect_sel),
    .chain_present(chain_present), .root_match(root_match),
    .key_count(key_count), .key_sig_ok(key_sig_ok), .hdr_sig_ok(hdr_sig_ok),
    .key_perm(key_perm), .key_cid(key_cid), .cancel_fuse(cancel_fuse),
    .busy(busy), .done(done), .pass(pass), .win_idx(win_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  sect;
    logic [3:0]  pres;
    logic [3:0]  root;
    logic [7:0]  kcnt;
    logic [11:0] ksig;
    logic [3:0]  hsig;
    logic [47:0] perm;
    logic [11:0] unc;
    logic [31:0] fuse;
    logic        ep;
    logic [1:0]  ew;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'hF, 4'hF, 8'h55, 12'hFFF, 4'hF, 48'hFFF_FFF_FFF_FFF, 12'hFFF, 32'h0, 1'b1, 2'd0},
    '{2'd0, 4'hF, 4'hE, 8'h55, 12'hFFF, 4'hF, 48'hFFF_FFF_FFF_FFF, 12'hFFF, 32'h0, 1'b1, 2'd1},
    '{2'd0, 4'h0, 4'hF, 8'h55, 12'hFFF, 4'hF, 48'hFFF_FFF_FFF_FFF, 12'hFFF, 32'h0, 1'b0, 2'd0},
    '{2'd1, 4'hF, 4'hF, 8'h56, 12'hFFF, 4'hF, 48'hFFF_FFF_FF2_F1F, 12'hFFF, 32'h0, 1'b1, 2'd1},
    '{2'd0, 4'hF, 4'hF, 8'h55, 12'hFFF, 4'hF, 48'hFFF_FFF_FFF_FFF, 12'h000, 32'h1, 1'b0, 2'd0},
    '{2'd0, 4'hF, 4'hF, 8'h45, 12'hFFF, 4'hF, 48'hFFF_FFF_FFF_FFF, 12'h000, 32'h1, 1'b1, 2'd2},
    '{2'd0, 4'hF, 4'hF, 8'h55, 12'hFFF, 4'hF, 48'hFFF_FFF_FFF_FFF, 12'hFFF, 32'h1, 1'b1, 2'd0},
    '{2'd3, 4'hB, 4'hF, 8'h55, 12'hFFE, 4'hD, 48'hFFF_FFF_FFF_FFF, 12'hFFF, 32'h0, 1'b1, 2'd3},
    '{2'd2, 4'hF, 4'hF, 8'hFF, 12'hFFF, 4'hF, 48'hBBB_BBB_BBB_BBB, 12'hFFF, 32'h0, 1'b0, 2'd0},
    '{2'd2, 4'hF, 4'hF, 8'hFF, 12'hFFF, 4'hF, 48'h666_666_666_666, 12'hFFF, 32'h0, 1'b1, 2'd0}
  };

  // Latency from the requirements: per chain 1 (root) + keys examined + 1 if header reached.
  function automatic int lat_model(vec_t v);
    int t = 0;
    for (int c = 0; c < 4; c++) begin
      logic [3:0] acc;
      logic ok;
      t++;
      if (!(v.pres[c] && v.root[c])) continue;
      acc = 4'hF;
      ok = 1'b1;
      for (int k = 0; k < int'(v.kcnt[c*2 +: 2]); k++) begin
        t++;
        if (!v.ksig[c*3+k] || (!v.unc[c*3+k] && v.fuse[0])) begin
          ok = 1'b0;
          break;
        end
        acc = acc & v.perm[c*12+k*4 +: 4];
      end
      if (!ok) continue;
      t++;
      if (v.hsig[c] && acc[v.sect]) return t;
    end
    return t;
  endfunction

  task automatic apply(vec_t v);
    sect_sel      = v.sect;
    chain_present = v.pres;
    root_match    = v.root;
    key_count     = v.kcnt;
    key_sig_ok    = v.ksig;
    hdr_sig_ok    = v.hsig;
    key_perm      = v.perm;
    cancel_fuse   = v.fuse;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 3; k++)
        key_cid[c][k] = {v.unc[c*3+k], 5'd0};
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pulses start (called at a negedge), returns the latency in clock edges.
  task automatic run(output int lat, input int poke_at);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done) break;
      start = (lat == poke_at);
      if (lat == poke_at) begin
        @(posedge clk);
        lat++;
        @(negedge clk);
        start = 1'b0;
        if (done) break;
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int lat;
    vec_t v;
    start = 1'b0;
    apply(VECS[0]);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "pass", int'(pass), 0);
    check("R1", "win_idx", int'(win_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      run(lat, -1);
      check("R8/R9", $sformatf("vec%0d pass", i), int'(pass), int'(VECS[i].ep));
      check("R8/R9", $sformatf("vec%0d win_idx", i), int'(win_idx), int'(VECS[i].ew));
      check("R4", $sformatf("vec%0d latency", i), lat, lat_model(VECS[i]));
      @(negedge clk);
    end

    // R5: ID 31 cancelled by fuse 31, unaffected by fuse 30
    v = VECS[2];
    v.pres = 4'h1;
    v.unc  = 12'h000;
    apply(v);
    key_cid[0][0] = {1'b0, 5'd31};
    cancel_fuse = 32'h8000_0000;
    @(negedge clk);
    run(lat, -1);
    check("R5", "id31 blown pass", int'(pass), 0);
    check("R5", "id31 blown latency", lat, 5);
    cancel_fuse = 32'h4000_0000;
    @(negedge clk);
    run(lat, -1);
    check("R5", "id31 intact pass", int'(pass), 1);
    check("R5", "id31 intact latency", lat, 3);
    // R5: same ID with flag set survives blown fuse
    key_cid[0][0] = {1'b1, 5'd31};
    cancel_fuse = 32'h8000_0000;
    @(negedge clk);
    run(lat, -1);
    check("R5", "fixed key pass", int'(pass), 1);

    // R6: third key entry narrows permission; root-only not used here
    v = VECS[9];
    v.perm = 48'h666_666_666_266;
    apply(v);
    @(negedge clk);
    run(lat, -1);
    check("R6", "third key perm win_idx", int'(win_idx), 1);
    check("R6", "third key perm latency", lat, 10);

    // R2: start while busy is ignored
    apply(VECS[8]);
    @(negedge clk);
    run(lat, 5);
    check("R2", "busy start pass", int'(pass), 0);
    check("R2", "busy start latency", lat, 20);

    // R10: result held after done; done is a pulse
    apply(VECS[7]);
    @(negedge clk);
    run(lat, -1);
    check("R10", "done pulse first", int'(done), 1);
    repeat (5) @(negedge clk);
    check("R10", "done dropped", int'(done), 0);
    check("R10", "busy low", int'(busy), 0);
    check("R10", "held pass", int'(pass), 1);
    check("R10", "held win_idx", int'(win_idx), 3);
    // R10: start clears the result before the new decision
    apply(VECS[2]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after start", int'(busy), 1);
    check("R10", "pass cleared on start", int'(pass), 0);
    repeat (6) @(negedge clk);

    summary();
    $finish;
  end
endmodule